// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a T1 receive path for the far end's remote alarm, also called the yellow alarm. It works in both framing families.

With extended superframe framing, the alarm is a repeating 16-bit codeword carried on the facility data link. The block sets its raw alarm after an unbroken run of matching codewords. It clears the raw alarm only once the recent history of codeword slots shows enough misses. This asymmetric rule keeps single bit errors from toggling the alarm.

With D4 framing, a select input picks one of two alarm signals. The first is bit 2 forced to zero in every channel of a frame. The second is a one in the S-bit of frame 12.

In extended superframe mode, an optional integration stage can be switched in on top of the raw status. It uses a 1 ms tick and changes the reported alarm only after the raw status has disagreed with it for more than 200 ms. This lets the alarm ride through interruptions of up to 100 ms.

Frame alignment and data link extraction happen upstream. They deliver the strobed bits and the frame-12 S-bit that this block consumes.

Top module: `t1_remote_alarm`

## Requirements
- R1: In ESF mode (`esf_mode`=1), every 16 accepted data link bits (`dl_valid`=1) form one codeword slot, counted from reset. A slot matches when, in arrival order, it holds eight zeros followed by eight ones (00FF hex, first bit received is the most significant). `alarm_raw` sets when 16 consecutive slots have matched.
- R2: In ESF mode, once set, `alarm_raw` stays set while at least 15 of the last 16 slots matched. It clears as soon as 14 or fewer of the last 16 slots matched.
- R3: The ESF raw status changes only on the clock edge that accepts the final bit of a slot, and it is visible right after that edge.
- R4: With `integ_en`=1 in ESF mode, `alarm_out` rises only after `alarm_raw` has been 1 for more than 200 ticks. It changes on the edge that samples the 201st `tick_1ms` pulse seen while `alarm_raw` differs from `alarm_out`.
- R5: Under integration, `alarm_out` falls by the same rule: after 201 ticks with `alarm_raw` at 0.
- R6: Under integration, a raw interruption of 100 ticks or fewer leaves `alarm_out` unchanged. Each return of agreement between the two statuses restarts the tick count.
- R7: In D4 mode with `d4_sbit_sel`=0, the raw alarm is evaluated on each `frame_end` strobe. It is 1 when no channel bit 2 sampled in that frame (`ch_bit2_valid`, including one on the `frame_end` cycle) was 1, and 0 otherwise.
- R8: In D4 mode with `d4_sbit_sel`=1, the raw alarm takes the value of `sbit` on each `sbit_valid` strobe, where `sbit_valid` marks the S-bit of frame 12.
- R9: When integration is not in force (`integ_en`=0, or D4 mode), `alarm_out` equals `alarm_raw` in the same cycle.
- R10: After reset both outputs are 0, the history holds no matches and integration is off until `integ_en` is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 = ESF codeword detection, 0 = D4 detection |
| d4_sbit_sel | input | 1 | D4 alarm select: 0 = bit 2 of all channels, 1 = frame-12 S-bit |
| integ_en | input | 1 | Enables 200 ms integration in ESF mode |
| dl_bit | input | 1 | Data link bit |
| dl_valid | input | 1 | Strobe for `dl_bit` |
| ch_bit2 | input | 1 | Bit 2 of the current channel |
| ch_bit2_valid | input | 1 | Strobe for `ch_bit2` |
| frame_end | input | 1 | Marks the last cycle of a D4 frame |
| sbit | input | 1 | S-bit of frame 12 |
| sbit_valid | input | 1 | Strobe for `sbit` |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| alarm_raw | output | 1 | Raw alarm status for the selected mode |
| alarm_out | output | 1 | Reported (integrated or bypassed) alarm status |

## Verification
The raw status is due one clock after the strobe that completes a slot, a frame or an S-bit. The integrated status is due one clock after the 201st qualifying tick. A behavioural model in the bench is updated on the same rising edge as the design. Both outputs are compared with the model on every falling edge, after the edge that produced them and before the next inputs are driven. Directed checks placed right after each slot, frame end or tick burst pin down the count boundaries: 15 versus 16 codewords, one miss versus two, and 200 versus 201 ticks.

// File: rtl/t1_remote_alarm.sv
module t1_remote_alarm #(
  parameter int                 CW_BITS  = 16,
  parameter logic [CW_BITS-1:0] CODEWORD = 16'h00FF,
  parameter int                 HIST     = 16,
  parameter int                 SET_RUN  = 16,
  parameter int                 CLR_MAX  = 14,
  parameter int                 INTEG_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic d4_sbit_sel,
  input  logic integ_en,
  input  logic dl_bit,
  input  logic dl_valid,
  input  logic ch_bit2,
  input  logic ch_bit2_valid,
  input  logic frame_end,
  input  logic sbit,
  input  logic sbit_valid,
  input  logic tick_1ms,
  output logic alarm_raw,
  output logic alarm_out
);
  localparam int SLW = $clog2(CW_BITS);
  localparam int RUNW = $clog2(SET_RUN + 1);
  localparam int MSW = $clog2(INTEG_MS + 1);

  logic [CW_BITS-1:0] sr;
  logic [SLW-1:0]     slot;
  logic [HIST-1:0]    hist;
  logic [RUNW-1:0]    run;
  logic               esf_raw, b2_raw, s_raw, seen_one, integ;
  logic [MSW-1:0]     ms_cnt;

  wire                esf_step  = esf_mode & dl_valid;
  wire [CW_BITS-1:0]  sr_nx     = {sr[CW_BITS-2:0], dl_bit};
  wire                slot_done = esf_step && (slot == SLW'(CW_BITS - 1));
  wire                hit       = (sr_nx == CODEWORD);
  wire [HIST-1:0]     hist_nx   = {hist[HIST-2:0], hit};
  wire [RUNW-1:0]     run_nx    = !hit ? '0 : (run == RUNW'(SET_RUN)) ? run : run + 1'b1;
  wire                seen_nx   = seen_one | (ch_bit2_valid & ch_bit2);
  wire                raw_sel   = esf_mode ? esf_raw : (d4_sbit_sel ? s_raw : b2_raw);
  wire                use_integ = integ_en & esf_mode;

  assign alarm_raw = raw_sel;
  assign alarm_out = use_integ ? integ : raw_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
      slot <= '0;
      hist <= '0;
      run <= '0;
      esf_raw <= 1'b0;
    end else if (esf_step) begin
      sr <= sr_nx;
      slot <= slot_done ? '0 : slot + 1'b1;
      if (slot_done) begin
        hist <= hist_nx;
        run <= run_nx;
        if (run_nx == RUNW'(SET_RUN)) esf_raw <= 1'b1;
        else if ($countones(hist_nx) <= CLR_MAX) esf_raw <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_one <= 1'b0;
      b2_raw <= 1'b0;
      s_raw <= 1'b0;
    end else if (!esf_mode) begin
      if (!d4_sbit_sel) begin
        if (frame_end) begin
          b2_raw <= ~seen_nx;
          seen_one <= 1'b0;
        end else begin
          seen_one <= seen_nx;
        end
      end else if (sbit_valid) begin
        s_raw <= sbit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= 1'b0;
      ms_cnt <= '0;
    end else if (!use_integ || (raw_sel == integ)) begin
      integ <= raw_sel;
      ms_cnt <= '0;
    end else if (tick_1ms) begin
      if (ms_cnt == MSW'(INTEG_MS)) begin
        integ <= ~integ;
        ms_cnt <= '0;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  // R1
  set_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esf_raw) |-> (&hist));

  // R2
  clear_needs_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(esf_raw) |-> ($countones(hist) <= CLR_MAX));

  // R3
  slot_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esf_raw != $past(esf_raw)) |-> $past(slot_done));

  // R4
  integ_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_integ && $past(use_integ) && (integ != $past(integ)))
      |-> ($past(tick_1ms) && ($past(ms_cnt) == MSW'(INTEG_MS))));

  // R6
  ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt <= MSW'(INTEG_MS));

  // R1
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUNW'(SET_RUN));
endmodule

// File: tb/test_t1_remote_alarm.sv
`timescale 1ns/100ps
module test_t1_remote_alarm;
  logic clk = 0, rst_n = 0;
  logic esf_mode = 1, d4_sbit_sel = 0, integ_en = 0;
  logic dl_bit = 0, dl_valid = 0, ch_bit2 = 0, ch_bit2_valid = 0, frame_end = 0;
  logic sbit = 0, sbit_valid = 0, tick_1ms = 0;
  logic alarm_raw, alarm_out;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  t1_remote_alarm i_t1_remote_alarm (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .d4_sbit_sel(d4_sbit_sel),
    .integ_en(integ_en), .dl_bit(dl_bit), .dl_valid(dl_valid), .ch_bit2(ch_bit2),
    .ch_bit2_valid(ch_bit2_valid), .frame_end(frame_end), .sbit(sbit),
    .sbit_valid(sbit_valid), .tick_1ms(tick_1ms), .alarm_raw(alarm_raw), .alarm_out(alarm_out));

  // behavioural reference
  bit slot_bits[$];
  bit hq[$];
  int consec = 0, m_cnt = 0;
  bit m_esf = 0, m_b2 = 0, m_s = 0, m_seen = 0, m_integ = 0;

  function automatic bit m_raw();
    if (esf_mode) return m_esf;
    return d4_sbit_sel ? m_s : m_b2;
  endfunction

  function automatic bit m_out();
    return (integ_en && esf_mode) ? m_integ : m_raw();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      slot_bits.delete(); hq.delete();
      consec = 0; m_cnt = 0; m_esf = 0; m_b2 = 0; m_s = 0; m_seen = 0; m_integ = 0;
    end else begin
      bit rs;
      rs = m_raw();
      if (!(integ_en && esf_mode)) begin m_integ = rs; m_cnt = 0; end
      else if (rs == m_integ) m_cnt = 0;
      else if (tick_1ms) begin
        if (m_cnt == 200) begin m_integ = !m_integ; m_cnt = 0; end
        else m_cnt++;
      end
      if (esf_mode && dl_valid) begin
        slot_bits.push_back(dl_bit);
        if (slot_bits.size() == 16) begin
          bit ok;
          int ones;
          ok = 1;
          for (int i = 0; i < 16; i++) if (slot_bits[i] != (i >= 8)) ok = 0;
          slot_bits.delete();
          hq.push_back(ok);
          if (hq.size() > 16) void'(hq.pop_front());
          consec = ok ? consec + 1 : 0;
          ones = 0;
          foreach (hq[i]) ones += hq[i];
          if (consec >= 16) m_esf = 1;
          else if (ones <= 14) m_esf = 0;
        end
      end
      if (!esf_mode && !d4_sbit_sel) begin
        bit any;
        any = m_seen || (ch_bit2_valid && ch_bit2);
        if (frame_end) begin m_b2 = !any; m_seen = 0; end
        else m_seen = any;
      end
      if (!esf_mode && d4_sbit_sel && sbit_valid) m_s = sbit;
    end
  end

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, "alarm_raw vs model", alarm_raw, m_raw());
      check(cur_req, "alarm_out vs model", alarm_out, m_out());
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); #1;
      dl_bit = w[i]; dl_valid = 1;
    end
    @(negedge clk); #1;
    dl_valid = 0;
  endtask

  task automatic send_words(int n, logic [15:0] w);
    for (int k = 0; k < n; k++) send_word(w);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1; tick_1ms = 1;
      @(negedge clk); #1; tick_1ms = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    @(negedge clk); @(negedge clk); #1; rst_n = 1;
  endtask

  task automatic d4_frame(int hot_ch);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk); #1;
      ch_bit2_valid = 1; ch_bit2 = (c == hot_ch);
      frame_end = (c == 23);
    end
    @(negedge clk); #1;
    ch_bit2_valid = 0; ch_bit2 = 0; frame_end = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R10", "raw after reset", alarm_raw, 1'b0);
    check("R10", "out after reset", alarm_out, 1'b0);

    cur_req = "R1";
    send_words(15, 16'h00FF);
    check("R1", "15 codewords", alarm_raw, 1'b0);
    cur_req = "R3";
    send_word(16'h00FF);
    check("R3", "16th codeword visible after slot", alarm_raw, 1'b1);
    check("R9", "out follows raw without integration", alarm_out, 1'b1);

    cur_req = "R2";
    send_word(16'h0000);
    check("R2", "one miss holds", alarm_raw, 1'b1);
    send_words(3, 16'h00FF);
    send_word(16'hFF00);
    check("R2", "two misses in 16 clears", alarm_raw, 1'b0);

    cur_req = "R1";
    do_reset();
    send_words(10, 16'h00FF);
    send_word(16'h01FF);
    send_words(15, 16'h00FF);
    check("R1", "broken run of 15 after miss", alarm_raw, 1'b0);
    send_word(16'h00FF);
    check("R1", "run of 16 after miss", alarm_raw, 1'b1);

    cur_req = "R4";
    do_reset();
    integ_en = 1;
    send_words(16, 16'h00FF);
    check("R4", "raw set", alarm_raw, 1'b1);
    check("R4", "out still low", alarm_out, 1'b0);
    ticks(200);
    check("R4", "200 ticks not enough", alarm_out, 1'b0);
    ticks(1);
    check("R4", "201st tick asserts", alarm_out, 1'b1);

    cur_req = "R6";
    send_words(2, 16'h0000);
    check("R6", "raw dropped", alarm_raw, 1'b0);
    ticks(100);
    send_words(16, 16'h00FF);
    ticks(50);
    check("R6", "100 tick interruption tolerated", alarm_out, 1'b1);

    cur_req = "R5";
    send_words(2, 16'h0000);
    ticks(200);
    check("R5", "200 ticks absent keeps alarm", alarm_out, 1'b1);
    ticks(1);
    check("R5", "201st tick clears", alarm_out, 1'b0);

    cur_req = "R7";
    esf_mode = 0; d4_sbit_sel = 0;
    d4_frame(-1);
    check("R7", "all bit2 zero", alarm_raw, 1'b1);
    check("R9", "D4 bypasses integration", alarm_out, 1'b1);
    d4_frame(5);
    check("R7", "one channel bit2 set", alarm_raw, 1'b0);
    d4_frame(23);
    check("R7", "bit2 set on frame_end cycle", alarm_raw, 1'b0);
    d4_frame(-1);
    check("R7", "alarm frame again", alarm_raw, 1'b1);

    cur_req = "R8";
    d4_sbit_sel = 1;
    @(negedge clk); #1; sbit = 1; sbit_valid = 1;
    @(negedge clk); #1; sbit_valid = 0; sbit = 0;
    check("R8", "S-bit one", alarm_raw, 1'b1);
    @(negedge clk); #1; sbit = 0; sbit_valid = 1;
    @(negedge clk); #1; sbit_valid = 0;
    check("R8", "S-bit zero", alarm_raw, 1'b0);
    check("R9", "out equals raw in D4", alarm_out, 1'b0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule